// File: doc/BRIEF.md
# Memory Fault Priority Encoder and Status Capture

This block sits at the end of a memory-access pipeline. In any cycle the pipeline may raise several fault-request flags at once. The block picks the one with the highest fixed priority. It builds a 32-bit fault status word from that fault's 5-bit code, the 4-bit domain number and the bus response type. It then writes the word into the data-side or instruction-side status register and captures the faulting addresses.

The abort strobe is combinational: it is high in every cycle in which any flag is set. The four captured registers load on the rising edge at which the strobe is high.

A translation fault raised during an instruction-cache maintenance operation by virtual address is split across both status registers. The data-side register records that a maintenance fault happened. The instruction-side register records the real reason.

Top module: `mmu_fault_capture`

## Requirements
- R1: Each bit of `flt_req_i` is one fault kind: 0 alignment, 1 TLB miss, 2 instruction-cache maintenance translation fault, 3 external abort on translation walk, 4 translation, 5 access-bit, 6 domain, 7 permission, 8 precise external abort, 9 imprecise external abort, 10 parity error, 11 debug event. The lowest set bit wins.
- R2: In a status word, bit 10 and bits 3:0 hold the 5-bit code, with bit 10 as the most significant code bit. Bit 12 holds the response bit and bits 7:4 hold the domain. All other bits are zero.
- R3: Faults that have a single encoding use these codes: alignment 00001, TLB miss 00000, maintenance 00100, precise 01000, imprecise 10110, parity 11000, debug 00010. No other code is ever produced besides the ones listed in R3 and R4.
- R4: With `page_i`=0 (section) or `page_i`=1 (page), the codes are: translation 00101/00111, access-bit 00011/00110, domain 01001/01011, permission 01101/01111. An external abort on translation gives 01100 when `walk_l2_i`=0 and 01110 when `walk_l2_i`=1.
- R5: Bits 7:4 carry `dom_i` only for these faults: a second-level walk external abort, a page translation fault, access-bit, domain, permission, precise external abort and debug event. For every other fault they are zero.
- R6: Bit 12 equals `slv_err_i` (1 means slave error, 0 means decode error) for translation-walk, precise and imprecise external aborts. For every other fault it is zero.
- R7: When the winning fault is the maintenance fault, four things load: DFSR gets code 00100 with domain and bit 12 at zero, IFSR gets the translation-fault word for `page_i` following the R5 rule, FAR gets `va_i` and IFAR gets `pc_i`. This happens whatever the value of `side_i`.
- R8: On a data-side abort (`side_i`=0), DFSR and FAR load and IFSR holds. IFAR loads `pc_i` only when `dmaint_i`=1 and holds otherwise.
- R9: On an instruction-side abort (`side_i`=1), IFSR loads with its domain bits at zero and IFAR loads `pc_i`. DFSR and FAR hold.
- R10: `abort_o` is high in a cycle exactly when any flag is set. The registers load only at an edge where `abort_o` is high. With no flag set, nothing changes.
- R11: When reset is asserted, all four registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flt_req_i | input | 12 | Fault request flags, one per kind |
| page_i | input | 1 | 1 = page mapping, 0 = section |
| walk_l2_i | input | 1 | Walk abort happened at the second level |
| slv_err_i | input | 1 | 1 = slave error response, 0 = decode error |
| dom_i | input | 4 | Domain number |
| va_i | input | 32 | Faulting virtual address |
| pc_i | input | 32 | Address of the aborting instruction |
| side_i | input | 1 | 1 = instruction side, 0 = data side |
| dmaint_i | input | 1 | Data-side fault came from a data-cache maintenance operation |
| abort_o | output | 1 | Abort strobe |
| dfsr_o | output | 32 | Data-side fault status |
| ifsr_o | output | 32 | Instruction-side fault status |
| far_o | output | 32 | Fault address |
| ifar_o | output | 32 | Instruction fault address |

## Verification
The abort strobe is combinational. The bench drives the inputs on a falling edge and samples `abort_o` 1 ns later, in the same cycle. The register outputs change on the rising edge in the middle of that cycle, so the bench compares all four registers at the next falling edge and only then removes the stimulus. Each step holds an expected copy of all four registers and compares every one of them. A register that should hold its value is therefore checked as well as one that should load.

// File: rtl/fault_cap_pkg.sv
package fault_cap_pkg;
  localparam int NUM_KINDS = 12;
  localparam int KW        = $clog2(NUM_KINDS);
  localparam int SW        = 32;
  localparam int DW        = 4;
  localparam int RESP_BIT  = 12;
  localparam int CODE_HI   = 10;
  localparam int DOM_LO    = 4;

  typedef enum logic [KW-1:0] {
    FK_ALIGN  = 4'd0,
    FK_TLB    = 4'd1,
    FK_ICM    = 4'd2,
    FK_WALKX  = 4'd3,
    FK_XLAT   = 4'd4,
    FK_ACCESS = 4'd5,
    FK_DOMAIN = 4'd6,
    FK_PERM   = 4'd7,
    FK_PRECX  = 4'd8,
    FK_IMPX   = 4'd9,
    FK_PARITY = 4'd10,
    FK_DEBUG  = 4'd11
  } fault_kind_e;

  function automatic logic code_legal(input logic [4:0] c);
    case (c)
      5'b00000, 5'b00001, 5'b00010, 5'b00011, 5'b00100, 5'b00101,
      5'b00110, 5'b00111, 5'b01000, 5'b01001, 5'b01011, 5'b01100,
      5'b01101, 5'b01110, 5'b01111, 5'b10110, 5'b11000: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic code_has_resp(input logic [4:0] c);
    return (c == 5'b01100) || (c == 5'b01110) || (c == 5'b01000) || (c == 5'b10110);
  endfunction

  function automatic logic code_has_dom(input logic [4:0] c);
    case (c)
      5'b01110, 5'b00111, 5'b00011, 5'b00110, 5'b01001,
      5'b01011, 5'b01101, 5'b01111, 5'b01000, 5'b00010: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fault_prio_sel.sv
module fault_prio_sel #(
  parameter int N  = 12,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // descending scan: the lowest set index is written last and wins
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = IW'(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/fault_word_enc.sv
module fault_word_enc
  import fault_cap_pkg::*;
(
  input  fault_kind_e   kind_i,
  input  logic          page_i,
  input  logic          l2_i,
  input  logic          slv_i,
  input  logic [DW-1:0] dom_i,
  input  logic          dom_en_i,
  output logic [SW-1:0] word_o
);
  logic [4:0] code;
  logic       dom_ok;
  logic       resp_ok;

  always_comb begin
    code    = 5'b00000;
    dom_ok  = 1'b0;
    resp_ok = 1'b0;
    unique case (kind_i)
      FK_ALIGN:  code = 5'b00001;
      FK_TLB:    code = 5'b00000;
      FK_ICM:    code = 5'b00100;
      FK_WALKX:  begin code = l2_i ? 5'b01110 : 5'b01100; dom_ok = l2_i; resp_ok = 1'b1; end
      FK_XLAT:   begin code = page_i ? 5'b00111 : 5'b00101; dom_ok = page_i; end
      FK_ACCESS: begin code = page_i ? 5'b00110 : 5'b00011; dom_ok = 1'b1; end
      FK_DOMAIN: begin code = page_i ? 5'b01011 : 5'b01001; dom_ok = 1'b1; end
      FK_PERM:   begin code = page_i ? 5'b01111 : 5'b01101; dom_ok = 1'b1; end
      FK_PRECX:  begin code = 5'b01000; dom_ok = 1'b1; resp_ok = 1'b1; end
      FK_IMPX:   begin code = 5'b10110; resp_ok = 1'b1; end
      FK_PARITY: code = 5'b11000;
      FK_DEBUG:  begin code = 5'b00010; dom_ok = 1'b1; end
      default:   code = 5'b00000;
    endcase
  end

  always_comb begin
    word_o                            = '0;
    word_o[3:0]                       = code[3:0];
    word_o[CODE_HI]                   = code[4];
    word_o[RESP_BIT]                  = resp_ok & slv_i;
    word_o[DOM_LO +: DW]              = (dom_ok & dom_en_i) ? dom_i : '0;
  end
endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture
  import fault_cap_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_KINDS-1:0] flt_req_i,
  input  logic                 page_i,
  input  logic                 walk_l2_i,
  input  logic                 slv_err_i,
  input  logic [DW-1:0]        dom_i,
  input  logic [AW-1:0]        va_i,
  input  logic [AW-1:0]        pc_i,
  input  logic                 side_i,
  input  logic                 dmaint_i,
  output logic                 abort_o,
  output logic [SW-1:0]        dfsr_o,
  output logic [SW-1:0]        ifsr_o,
  output logic [AW-1:0]        far_o,
  output logic [AW-1:0]        ifar_o
);
  logic [NUM_KINDS-1:0] gnt;
  logic [KW-1:0]        idx;
  logic                 any;
  fault_kind_e          kind;
  logic [SW-1:0]        sel_word;
  logic [SW-1:0]        rsn_word;
  logic                 is_icm;

  fault_prio_sel #(.N(NUM_KINDS)) u_prio (
    .req_i (flt_req_i),
    .gnt_o (gnt),
    .idx_o (idx),
    .any_o (any)
  );

  assign kind    = fault_kind_e'(idx);
  assign is_icm  = (kind == FK_ICM);
  assign abort_o = any;

  // primary word: domain suppressed on the instruction side
  fault_word_enc u_enc_sel (
    .kind_i   (kind),
    .page_i   (page_i),
    .l2_i     (walk_l2_i),
    .slv_i    (slv_err_i),
    .dom_i    (dom_i),
    .dom_en_i (~side_i),
    .word_o   (sel_word)
  );

  // real reason behind a maintenance fault, routed to IFSR
  fault_word_enc u_enc_rsn (
    .kind_i   (FK_XLAT),
    .page_i   (page_i),
    .l2_i     (1'b0),
    .slv_i    (1'b0),
    .dom_i    (dom_i),
    .dom_en_i (1'b1),
    .word_o   (rsn_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dfsr_o <= '0;
      ifsr_o <= '0;
      far_o  <= '0;
      ifar_o <= '0;
    end else if (any) begin
      if (is_icm) begin
        dfsr_o <= sel_word & ~(SW'(1) << RESP_BIT);
        ifsr_o <= rsn_word;
        far_o  <= va_i;
        ifar_o <= pc_i;
      end else if (!side_i) begin
        dfsr_o <= sel_word;
        far_o  <= va_i;
        if (dmaint_i) ifar_o <= pc_i;
      end else begin
        ifsr_o <= sel_word;
        ifar_o <= pc_i;
      end
    end
  end

  p_grant_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt) && (abort_o == (gnt != '0)));

  p_code_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_legal({dfsr_o[CODE_HI], dfsr_o[3:0]}) && code_legal({ifsr_o[CODE_HI], ifsr_o[3:0]}));

  p_dom_rule_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dfsr_o[DOM_LO +: DW] != '0) |-> code_has_dom({dfsr_o[CODE_HI], dfsr_o[3:0]}));

  p_resp_rule_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dfsr_o[RESP_BIT] |-> code_has_resp({dfsr_o[CODE_HI], dfsr_o[3:0]}));

  p_icm_split_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && is_icm) |=> ({dfsr_o[CODE_HI], dfsr_o[3:0]} == 5'b00100) && (far_o == $past(va_i)));

  p_iside_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && side_i && !is_icm) |=> $stable(far_o) && $stable(dfsr_o));

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !abort_o |=> $stable(dfsr_o) && $stable(ifsr_o) && $stable(far_o) && $stable(ifar_o));
endmodule

// File: tb/mmu_fault_capture_tb.sv
module mmu_fault_capture_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] flt_req_i = '0;
  logic        page_i = 1'b0, walk_l2_i = 1'b0, slv_err_i = 1'b0;
  logic [3:0]  dom_i = '0;
  logic [31:0] va_i = '0, pc_i = '0;
  logic        side_i = 1'b0, dmaint_i = 1'b0;
  logic        abort_o;
  logic [31:0] dfsr_o, ifsr_o, far_o, ifar_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] e_dfsr = '0, e_ifsr = '0, e_far = '0, e_ifar = '0;

  always #2 clk_i = ~clk_i;

  mmu_fault_capture u_dut (
    .clk_i, .rst_ni, .flt_req_i, .page_i, .walk_l2_i, .slv_err_i, .dom_i,
    .va_i, .pc_i, .side_i, .dmaint_i, .abort_o, .dfsr_o, .ifsr_o, .far_o, .ifar_o
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [4:0] m_code(input int k, input bit pg, input bit l2);
    case (k)
      0: return 5'b00001;  1: return 5'b00000;  2: return 5'b00100;
      3: return l2 ? 5'b01110 : 5'b01100;
      4: return pg ? 5'b00111 : 5'b00101;
      5: return pg ? 5'b00110 : 5'b00011;
      6: return pg ? 5'b01011 : 5'b01001;
      7: return pg ? 5'b01111 : 5'b01101;
      8: return 5'b01000;  9: return 5'b10110;  10: return 5'b11000;
      default: return 5'b00010;
    endcase
  endfunction

  function automatic bit m_dv(input int k, input bit pg, input bit l2);
    return (k == 3 && l2) || (k == 4 && pg) || (k >= 5 && k <= 8) || k == 11;
  endfunction

  function automatic logic [31:0] m_word(input logic [4:0] c, input bit dv, input logic [3:0] d, input bit rb);
    return {19'b0, rb, 1'b0, c[4], 2'b0, dv ? d : 4'h0, c[3:0]};
  endfunction

  task automatic step(input string tag, input logic [11:0] fl, input bit pg, input bit l2,
                      input bit slv, input logic [3:0] d, input logic [31:0] va,
                      input logic [31:0] pc, input bit sd, input bit dm);
    int k = -1;
    for (int i = 11; i >= 0; i--) if (fl[i]) k = i;
    if (k == 2) begin
      e_dfsr = m_word(5'b00100, 0, d, 0);
      e_ifsr = m_word(m_code(4, pg, 0), m_dv(4, pg, 0), d, 0);
      e_far  = va;
      e_ifar = pc;
    end else if (k >= 0) begin
      bit rb = slv && (k == 3 || k == 8 || k == 9);
      if (!sd) begin
        e_dfsr = m_word(m_code(k, pg, l2), m_dv(k, pg, l2), d, rb);
        e_far  = va;
        if (dm) e_ifar = pc;
      end else begin
        e_ifsr = m_word(m_code(k, pg, l2), 0, d, rb);
        e_ifar = pc;
      end
    end
    @(negedge clk_i);
    flt_req_i = fl; page_i = pg; walk_l2_i = l2; slv_err_i = slv; dom_i = d;
    va_i = va; pc_i = pc; side_i = sd; dmaint_i = dm;
    #1;
    chk(tag, "abort_o (R10)", {31'b0, abort_o}, {31'b0, fl != 0});
    @(negedge clk_i);
    chk(tag, "dfsr", dfsr_o, e_dfsr);
    chk(tag, "ifsr", ifsr_o, e_ifsr);
    chk(tag, "far",  far_o,  e_far);
    chk(tag, "ifar", ifar_o, e_ifar);
    flt_req_i = '0;
  endtask

  task automatic t_reset();
    #1;
    chk("R11", "dfsr", dfsr_o, 0); chk("R11", "ifsr", ifsr_o, 0);
    chk("R11", "far", far_o, 0);   chk("R11", "ifar", ifar_o, 0);
    chk("R11", "abort", {31'b0, abort_o}, 0);
  endtask

  // every kind alone on the data side, section and page (R2 R3 R4 R5)
  task automatic t_single_kinds();
    for (int pg = 0; pg < 2; pg++)
      for (int k = 0; k < 12; k++)
        step(k == 3 || k >= 4 && k <= 7 ? "R4" : "R3", 12'(1) << k, pg[0], pg[0], 1'b0,
             4'(k + 3), 32'h1000_0000 + 32'(k), 32'h2000_0000 + 32'(k), 1'b0, 1'b0);
    step("R5", 12'h008, 0, 0, 0, 4'hA, 32'h11, 32'h12, 0, 0);
    step("R5", 12'h008, 0, 1, 0, 4'hA, 32'h13, 32'h14, 0, 0);
  endtask

  task automatic t_priority();
    step("R1", 12'hFFF, 1, 1, 1, 4'h5, 32'hA0, 32'hB0, 0, 0);
    step("R1", 12'hFF0, 1, 1, 1, 4'h5, 32'hA1, 32'hB1, 0, 0);
    step("R1", 12'h900, 0, 0, 1, 4'h6, 32'hA2, 32'hB2, 0, 0);
    step("R1", 12'hC00, 0, 0, 1, 4'h6, 32'hA3, 32'hB3, 0, 0);
    step("R1", 12'h0A2, 1, 0, 1, 4'h7, 32'hA4, 32'hB4, 0, 0);
    step("R1", 12'h0C0, 1, 0, 0, 4'h8, 32'hA5, 32'hB5, 0, 0);
  endtask

  task automatic t_resp_bit();
    step("R6", 12'h008, 0, 1, 1, 4'h2, 32'hC0, 32'hD0, 0, 0);
    step("R6", 12'h100, 0, 0, 1, 4'h2, 32'hC1, 32'hD1, 0, 0);
    step("R6", 12'h200, 0, 0, 1, 4'h2, 32'hC2, 32'hD2, 0, 0);
    step("R6", 12'h200, 0, 0, 0, 4'h2, 32'hC3, 32'hD3, 0, 0);
    step("R6", 12'h080, 1, 0, 1, 4'h2, 32'hC4, 32'hD4, 0, 0);
    step("R6", 12'h400, 0, 0, 1, 4'h2, 32'hC5, 32'hD5, 0, 0);
  endtask

  task automatic t_icm_split();
    step("R7", 12'h004, 0, 0, 1, 4'h9, 32'hE0, 32'hF0, 0, 0);
    step("R7", 12'h004, 1, 0, 1, 4'h9, 32'hE1, 32'hF1, 1, 0);
    step("R7", 12'h0F4, 1, 1, 1, 4'h3, 32'hE2, 32'hF2, 0, 0);
  endtask

  task automatic t_data_side();
    step("R8", 12'h010, 1, 0, 0, 4'h4, 32'h3000, 32'h4000, 0, 0);
    step("R8", 12'h010, 1, 0, 0, 4'h4, 32'h3004, 32'h4004, 0, 1);
  endtask

  task automatic t_instr_side();
    step("R9", 12'h800, 0, 0, 0, 4'hF, 32'h5000, 32'h6000, 1, 0);
    step("R9", 12'h080, 1, 0, 0, 4'hF, 32'h5004, 32'h6004, 1, 0);
    step("R9", 12'h100, 0, 0, 1, 4'hF, 32'h5008, 32'h6008, 1, 1);
  endtask

  task automatic t_idle();
    step("R10", 12'h000, 1, 1, 1, 4'hF, 32'hDEAD, 32'hBEEF, 0, 1);
    step("R10", 12'h000, 0, 0, 0, 4'h1, 32'h7777, 32'h8888, 1, 0);
  endtask

  initial begin
    t_reset();
    #9 rst_ni = 1'b1;
    t_single_kinds();
    t_priority();
    t_resp_bit();
    t_icm_split();
    t_data_side();
    t_instr_side();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule